// File: doc/BRIEF.md
# Reliability-Weighted Extended Hamming Decoder

This block decodes one 128-bit extended Hamming codeword per cycle. Every bit arrives as a 3-bit soft value. A sign bit gives the hard decision and a two-bit level gives the confidence. The decoder forms the hard word and its check signature in a first register stage. In a second stage it decides which bits to flip and registers the 120 information bits together with two status flags.

When the overall parity is odd, the word is treated as carrying one error, and the bit named by the syndrome is flipped. When the parity is even but the syndrome is not zero, the block does not simply give up. It locates the four least confident positions. Each of them is paired with the bit that would clear the syndrome, and the pair with the smallest total confidence is flipped. If no allowed pair exists, the block passes on the hard decisions and marks the word uncorrectable. The input never stalls once reset is released, so many instances can run side by side, one per codeword stream.

Top module: `soft_hamming_dec`

## Requirements
- R1: Codeword layout. Position 0 holds the overall parity, so the XOR of all 128 hard bits is zero. Positions 1, 2, 4, ... 64 hold the check bits, so the XOR of the indices of all set bits at positions 1..127 is zero. The remaining 120 positions, in ascending order, carry information bits 0..119, and `outData[j]` is the j-th of them. Soft value for bit i is `inSoft[3i+2:3i]`. Bit 3i+2 is the hard decision (1 = negative value), and bits 3i+1:3i form a level L with magnitude 2L+1.
- R2: A word with zero syndrome and even overall parity comes out unchanged, with both flags low.
- R3: A word with odd overall parity has the bit at the position equal to the syndrome flipped (position 0 when the syndrome is zero). `outCorrected` goes high and `outUncorrectable` stays low, whatever the magnitudes.
- R4: For even parity with a nonzero syndrome, the candidates are pairs (p, p XOR syndrome) where p is one of the four lowest-magnitude positions (ties go to the lower index). The pair with the smallest sum of magnitudes is flipped, and `outCorrected` goes high.
- R5: A pair candidate is never formed with a bit of magnitude 7. When no candidate remains, the hard information bits are output with `outUncorrectable` high and `outCorrected` low.
- R6: `inReady` is high whenever reset is low. A word accepted at a clock edge appears on the outputs with `outValid` high exactly two edges later. Words accepted on consecutive cycles come out on consecutive cycles, in order.
- R7: While reset is high, and on the edge after it, `outValid` is low.
- R8: Both flags are low whenever `outValid` is low, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A codeword is present on `inSoft` |
| inReady | output | 1 | Decoder accepts a word (high out of reset) |
| inSoft | input | 384 | 128 soft values, 3 bits each |
| outValid | output | 1 | Decoded word present |
| outData | output | 120 | Information bits |
| outCorrected | output | 1 | One or two bits were flipped |
| outUncorrectable | output | 1 | No allowed correction was found |

## Verification
The bench builds the block at its default sizes: a 7-bit syndrome (128-bit word) and four low-confidence positions. At that size a sweep over every single-error position is cheap, so each of the 128 positions is hit twice, once with the wrong bit at the lowest confidence and once at full confidence, under random level noise on the other bits. Double errors are placed with distinct low magnitudes on a background of 5s and 7s, so the expected pair choice is unambiguous. An all-7 background forces the no-candidate outcome.

// File: rtl/shd_pkg.sv
package shd_pkg;

  // Strobes from control to datapath: load stage 1, load output stage.
  typedef struct packed {
    logic ld1;
    logic ld2;
  } shd_strobe_t;

  // Position in the codeword of information bit j (skips 0 and powers of two).
  function automatic int infoPos(input int synW, input int j);
    int cnt;
    cnt = 0;
    for (int p = 1; p < (1 << synW); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/shd_ctrl.sv
module shd_ctrl
  import shd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  output shd_strobe_t st,
  output logic        outValid
);

  logic v1;

  assign inReady = !rst;
  assign st.ld1  = inValid && inReady;
  assign st.ld2  = v1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1       <= 1'b0;
      outValid <= 1'b0;
    end else begin
      v1       <= st.ld1;
      outValid <= v1;
    end
  end

  // R6
  lat_two_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> ##1 outValid);

  // R7
  rst_idle_chk: assert property (@(posedge clk) rst |=> !outValid);

endmodule

// File: rtl/shd_datapath.sv
module shd_datapath
  import shd_pkg::*;
#(
  parameter int SYN_W   = 7,
  parameter int LVL_W   = 2,
  parameter int NUM_LRP = 4,
  localparam int CW     = 1 << SYN_W,
  localparam int INFO   = CW - SYN_W - 1,
  localparam int SOFT_W = LVL_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  shd_strobe_t        st,
  input  logic [CW*SOFT_W-1:0] inSoft,
  output logic [INFO-1:0]    outData,
  output logic               outCorrected,
  output logic               outUncorrectable
);

  localparam int SCORE_W = LVL_W + 2;
  localparam logic [LVL_W-1:0] MAXLVL = '1;

  // ---------------- stage 1: hard decisions, syndrome, parity ----------------
  logic [CW-1:0]       hardIn;
  logic [CW*LVL_W-1:0] lvlIn;
  logic [SYN_W-1:0]    synIn;
  logic                parIn;

  for (genvar i = 0; i < CW; i++) begin : g_split
    assign hardIn[i]                 = inSoft[i*SOFT_W + LVL_W];
    assign lvlIn[i*LVL_W +: LVL_W]   = inSoft[i*SOFT_W +: LVL_W];
  end

  always_comb begin
    synIn = '0;
    parIn = 1'b0;
    for (int i = 0; i < CW; i++) begin
      if (hardIn[i]) begin
        synIn = synIn ^ SYN_W'(i);
        parIn = ~parIn;
      end
    end
  end

  logic [CW-1:0]       hardQ;
  logic [CW*LVL_W-1:0] lvlQ;
  logic [SYN_W-1:0]    synQ;
  logic                parQ;

  always_ff @(posedge clk) begin
    if (st.ld1) begin
      hardQ <= hardIn;
      lvlQ  <= lvlIn;
      synQ  <= synIn;
      parQ  <= parIn;
    end
  end

  function automatic logic [LVL_W-1:0] lvlAt(input logic [SYN_W-1:0] p);
    return lvlQ[int'(p)*LVL_W +: LVL_W];
  endfunction

  // ---------------- stage 2: least reliable positions ----------------
  logic [SYN_W-1:0] lrp [NUM_LRP];

  always_comb begin
    logic [CW-1:0]    taken;
    logic [LVL_W:0]   bestLvl;
    logic [SYN_W-1:0] bestIdx;
    taken = '0;
    for (int k = 0; k < NUM_LRP; k++) begin
      bestLvl = {1'b1, {LVL_W{1'b0}}};
      bestIdx = '0;
      for (int i = 0; i < CW; i++) begin
        if (!taken[i] && ({1'b0, lvlQ[i*LVL_W +: LVL_W]} < bestLvl)) begin
          bestLvl = {1'b0, lvlQ[i*LVL_W +: LVL_W]};
          bestIdx = SYN_W'(i);
        end
      end
      taken[bestIdx] = 1'b1;
      lrp[k] = bestIdx;
    end
  end

  // ---------------- stage 2: pair candidates and scoring ----------------
  logic [SYN_W-1:0]   pairA, pairB;
  logic               anyOk;

  always_comb begin
    logic [SYN_W-1:0]   partner;
    logic [LVL_W-1:0]   la, lb;
    logic [SCORE_W-1:0] score, bestScore;
    pairA     = '0;
    pairB     = '0;
    anyOk     = 1'b0;
    bestScore = '1;
    for (int k = 0; k < NUM_LRP; k++) begin
      partner = lrp[k] ^ synQ;
      la      = lvlAt(lrp[k]);
      lb      = lvlAt(partner);
      score   = {1'b0, la, 1'b1} + {1'b0, lb, 1'b1};
      if (la != MAXLVL && lb != MAXLVL && (!anyOk || score < bestScore)) begin
        anyOk     = 1'b1;
        bestScore = score;
        pairA     = lrp[k];
        pairB     = partner;
      end
    end
  end

  // ---------------- stage 2: decision ----------------
  logic [CW-1:0]   fixedWord;
  logic [INFO-1:0] infoComb;
  logic            corComb, uncComb;

  always_comb begin
    fixedWord = hardQ;
    corComb   = 1'b0;
    uncComb   = 1'b0;
    if (parQ) begin
      fixedWord[synQ] = ~fixedWord[synQ];
      corComb = 1'b1;
    end else if (synQ != '0) begin
      if (anyOk) begin
        fixedWord[pairA] = ~fixedWord[pairA];
        fixedWord[pairB] = ~fixedWord[pairB];
        corComb = 1'b1;
      end else begin
        uncComb = 1'b1;
      end
    end
  end

  for (genvar j = 0; j < INFO; j++) begin : g_info
    assign infoComb[j] = fixedWord[infoPos(SYN_W, j)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData          <= '0;
      outCorrected     <= 1'b0;
      outUncorrectable <= 1'b0;
    end else if (st.ld2) begin
      outData          <= infoComb;
      outCorrected     <= corComb;
      outUncorrectable <= uncComb;
    end else begin
      outCorrected     <= 1'b0;
      outUncorrectable <= 1'b0;
    end
  end

  // R2
  clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (st.ld2 && synQ == '0 && !parQ) |=> (!outCorrected && !outUncorrectable));

  // R3
  odd_fix_chk: assert property (@(posedge clk) disable iff (rst)
    (st.ld2 && parQ) |=> (outCorrected && !outUncorrectable));

  // R5
  even_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (st.ld2 && !parQ && synQ != '0) |=> (outCorrected || outUncorrectable));

endmodule

// File: rtl/soft_hamming_dec.sv
module soft_hamming_dec
  import shd_pkg::*;
#(
  parameter int SYN_W   = 7,
  parameter int LVL_W   = 2,
  parameter int NUM_LRP = 4,
  localparam int CW     = 1 << SYN_W,
  localparam int INFO   = CW - SYN_W - 1,
  localparam int SOFT_W = LVL_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [CW*SOFT_W-1:0] inSoft,
  output logic                 outValid,
  output logic [INFO-1:0]      outData,
  output logic                 outCorrected,
  output logic                 outUncorrectable
);

  shd_strobe_t st;

  shd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .st       (st),
    .outValid (outValid)
  );

  shd_datapath #(
    .SYN_W   (SYN_W),
    .LVL_W   (LVL_W),
    .NUM_LRP (NUM_LRP)
  ) u_dp (
    .clk              (clk),
    .rst              (rst),
    .st               (st),
    .inSoft           (inSoft),
    .outData          (outData),
    .outCorrected     (outCorrected),
    .outUncorrectable (outUncorrectable)
  );

  // R8
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (!outCorrected && !outUncorrectable));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(outCorrected && outUncorrectable));

endmodule

// File: tb/soft_hamming_dec_bench.sv
module soft_hamming_dec_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [383:0] inSoft = '0;
  logic         outValid;
  logic [119:0] outData;
  logic         outCorrected;
  logic         outUncorrectable;

  int checks = 0;
  int failures = 0;
  int sendCnt = 0;
  int recvCnt = 0;
  bit done = 1'b0;

  logic [119:0] expData [2048];
  bit           expCor  [2048];
  bit           expUnc  [2048];
  string        expTag  [2048];

  always #10 clk = ~clk;

  soft_hamming_dec u_soft_hamming_dec (
    .clk (clk), .rst (rst), .inValid (inValid), .inReady (inReady),
    .inSoft (inSoft), .outValid (outValid), .outData (outData),
    .outCorrected (outCorrected), .outUncorrectable (outUncorrectable)
  );

  function automatic bit isInfo(int p);
    return (p != 0) && ((p & (p - 1)) != 0);
  endfunction

  // R1: layout of information, check and overall parity bits
  function automatic logic [127:0] encodeWord(logic [119:0] d);
    logic [127:0] cw;
    logic [6:0]   s;
    int j;
    cw = '0; j = 0; s = '0;
    for (int p = 1; p < 128; p++) if (isInfo(p)) begin cw[p] = d[j]; j++; end
    for (int p = 1; p < 128; p++) if (cw[p]) s = s ^ 7'(p);
    for (int k = 0; k < 7; k++) cw[1 << k] = s[k];
    cw[0] = ^cw[127:1];
    return cw;
  endfunction

  function automatic logic [119:0] extractInfo(logic [127:0] cw);
    logic [119:0] d;
    int j;
    d = '0; j = 0;
    for (int p = 1; p < 128; p++) if (isInfo(p)) begin d[j] = cw[p]; j++; end
    return d;
  endfunction

  function automatic logic [119:0] randData();
    return {$urandom(), $urandom(), $urandom(), 24'($urandom())};
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one word at a negedge; it is accepted at the next posedge.
  task automatic sendWord(logic [127:0] hard, logic [255:0] lvls,
                          logic [119:0] d, bit c, bit u, string tag);
    logic [383:0] s;
    for (int i = 0; i < 128; i++) begin
      s[3*i +: 2] = lvls[2*i +: 2];
      s[3*i + 2]  = hard[i];
    end
    inSoft  = s;
    inValid = 1'b1;
    expData[sendCnt] = d;
    expCor[sendCnt]  = c;
    expUnc[sendCnt]  = u;
    expTag[sendCnt]  = tag;
    sendCnt++;
    @(negedge clk);
  endtask

  // Stream checker: every valid output against the expected queue (R6 order).
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (recvCnt >= sendCnt) begin
        check(1'b0, "R6 extra output", 128'(recvCnt), 128'(sendCnt));
      end else begin
        check(outData == expData[recvCnt], expTag[recvCnt],
              128'(outData), 128'(expData[recvCnt]));
        check(outCorrected == expCor[recvCnt] && outUncorrectable == expUnc[recvCnt],
              {expTag[recvCnt], " flags"},
              128'({outCorrected, outUncorrectable}),
              128'({expCor[recvCnt], expUnc[recvCnt]}));
      end
      recvCnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [119:0] d;
    logic [127:0] cw, bad;
    logic [255:0] lv;
    int e1, e2;

    // R7: reset state
    repeat (3) @(negedge clk);
    check(!outValid && !outCorrected && !outUncorrectable, "R7 reset outputs",
          128'({outValid, outCorrected, outUncorrectable}), 128'(0));
    check(!inReady, "R6 ready low in reset", 128'(inReady), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check(!outValid, "R7 after reset", 128'(outValid), 128'(0));
    check(inReady, "R6 ready high", 128'(inReady), 128'(1));

    // R6: latency of exactly two edges for an isolated word
    d = randData();
    sendWord(encodeWord(d), '1, d, 1'b0, 1'b0, "R6 isolated word");
    inValid = 1'b0;
    check(!outValid, "R6 not after one edge", 128'(outValid), 128'(0));
    @(negedge clk);
    check(outValid, "R6 valid after two edges", 128'(outValid), 128'(1));
    @(negedge clk);
    // R8: flags low once outValid drops
    check(!outValid && !outCorrected && !outUncorrectable, "R8 idle flags",
          128'({outValid, outCorrected, outUncorrectable}), 128'(0));

    // R1, R2: clean words under random levels, streamed back to back
    for (int n = 0; n < 16; n++) begin
      d = randData();
      for (int i = 0; i < 128; i++) lv[2*i +: 2] = 2'($urandom_range(3, 0));
      sendWord(encodeWord(d), lv, d, 1'b0, 1'b0, "R2 clean pass");
    end

    // R3: every single-error position, weak and full-confidence wrong bit
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < 128; p++) begin
        d = randData();
        cw = encodeWord(d);
        bad = cw; bad[p] = ~bad[p];
        for (int i = 0; i < 128; i++) lv[2*i +: 2] = 2'($urandom_range(3, 0));
        lv[2*p +: 2] = (pass == 0) ? 2'd0 : 2'd3;
        sendWord(bad, lv, d, 1'b1, 1'b0, "R3 single error");
      end
    end

    // R4: double error on the two weakest bits, background magnitudes 5 and 7
    for (int n = 0; n < 64; n++) begin
      d = randData();
      cw = encodeWord(d);
      e1 = $urandom_range(127, 0);
      e2 = (e1 + 1 + $urandom_range(126, 0)) % 128;
      bad = cw; bad[e1] = ~bad[e1]; bad[e2] = ~bad[e2];
      for (int i = 0; i < 128; i++) lv[2*i +: 2] = 2'($urandom_range(3, 2));
      lv[2*e1 +: 2] = 2'd0;
      lv[2*e2 +: 2] = 2'd1;
      sendWord(bad, lv, d, 1'b1, 1'b0, "R4 pair correction");
    end

    // R5: double errors where every candidate touches a magnitude-7 bit
    for (int n = 0; n < 32; n++) begin
      d = randData();
      cw = encodeWord(d);
      e1 = $urandom_range(127, 0);
      e2 = (e1 + 1 + $urandom_range(126, 0)) % 128;
      bad = cw; bad[e1] = ~bad[e1]; bad[e2] = ~bad[e2];
      lv = '1;
      if (n >= 16) lv[2*e1 +: 2] = 2'd0;
      sendWord(bad, lv, extractInfo(bad), 1'b0, 1'b1, "R5 uncorrectable");
    end

    inValid = 1'b0;
    repeat (4) @(negedge clk);
    // R6: every accepted word came out
    check(recvCnt == sendCnt, "R6 output count", 128'(recvCnt), 128'(sendCnt));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule